// File: doc/BRIEF.md
# Card Clock Divider with Bypass

This block derives the card-side clock from the master clock of a memory-card host. A divider value N produces a card clock whose period is 2·N master cycles, with equal high and low halves. A value of zero sends the master clock straight out. Zero is not allowed to mean "bypass" while double-data-rate transfers are selected, so in that mode it divides by two. A request to turn the clock off during power-on keeps the clock running at the largest divider the field can hold.

The block also registers the bus options that travel with the divider: a bus-width code, a high-speed flag and a flow-control enable. When flow control is on and the data FIFO reports that it cannot proceed, the card clock is parked low until the FIFO recovers. A one-master-cycle enable strobe tells the command and data logic when a launch edge of the card clock occurs. A new divider or mode is adopted only at a falling transition of the card clock. The path between bypass and divided output changes over while the master clock is low, so no runt pulse can reach the card.

Top module: `card_clk_div`

## Requirements
- R1: For a nonzero divider N with DDR off and no off-request, the card clock is high for exactly N master cycles and low for exactly N master cycles.
- R2: With divider 0, DDR off and no off-request, the card clock equals the master clock, and the enable strobe is high in every master cycle.
- R3: With DDR on, divider 0 behaves as divider 1: the card clock is high for 1 master cycle and low for 1 master cycle. It is never the master clock.
- R4: While the off-request is high, the divider used is the field maximum 2^DIV_W−1, whatever the divider input holds.
- R5: A divider change made while the card clock is high has no effect on the current high half. The following low half and later halves use the new value.
- R6: No high or low pulse on the card clock is shorter than half a master period, including at every change between bypass and divided output.
- R7: When the registered flow-control enable is 1 and fifo_stall is 1, the card clock is held low and the strobe stays 0, in divided and in bypass mode. fifo_stall has no effect while flow control is 0.
- R8: In divided mode the strobe pulses exactly once per card clock period, in the master cycle in which the card clock rises. With DDR on it also pulses in the cycle in which the card clock falls, giving two pulses per period.
- R9: bus_width is the registered bus-width request one cycle later, with the codes 00 for 1-bit, 01 for 4-bit and 10 for 8-bit. The unused code 11 is output as 00.
- R10: hs_bus and hwfc_en follow their requests one cycle later. ddr_act shows the DDR setting that is in force once a new setting has been adopted.
- R11: While reset is low, card_clk, clk_en, ddr_act, bus_width, hs_bus and hwfc_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | DIV_W | Divider request; 0 asks for bypass |
| clk_off_req | input | 1 | Clock-off request during power-on; forces the maximum divider |
| ddr_req | input | 1 | Double-data-rate mode request |
| bus_width_req | input | 2 | Bus-width code request |
| hs_req | input | 1 | High-speed bus request |
| hwfc_req | input | 1 | Flow-control enable request |
| fifo_stall | input | 1 | Data FIFO cannot accept or supply data |
| card_clk | output | 1 | Card clock |
| clk_en | output | 1 | Launch-edge enable strobe for command and data logic |
| ddr_act | output | 1 | DDR mode in force |
| bus_width | output | 2 | Registered bus-width code |
| hs_bus | output | 1 | Registered high-speed flag |
| hwfc_en | output | 1 | Registered flow-control enable |

## Verification
The update of the active divider is tied to the falling transition, so a divider change and a falling transition of the card clock can occur in the same master cycle. The bench changes the divider in the very cycle the card clock rises. It then checks that the current high half keeps its old length and that the halves after it take the new one. Flow-control parking can also collide with the cycle in which a rise is due. Here the bench asserts a stall with a short divider and checks over many samples that neither a rise nor a strobe leaks through. It then checks that normal periods resume once the stall ends.

// File: rtl/ckd_pkg.sv
package ckd_pkg;

  typedef enum logic [1:0] {
    BW_ONE   = 2'b00,
    BW_FOUR  = 2'b01,
    BW_EIGHT = 2'b10
  } bus_w_e;

  // map a requested width code onto a legal one; the spare code folds to 1-bit
  function automatic bus_w_e norm_width(input logic [1:0] code);
    case (code)
      2'b01:   return BW_FOUR;
      2'b10:   return BW_EIGHT;
      default: return BW_ONE;
    endcase
  endfunction

endpackage

// File: rtl/ckd_cfg_sel.sv
module ckd_cfg_sel #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div_val,
  input  logic             ddr_req,
  input  logic             off_req,
  output logic [DIV_W-1:0] req_half,
  output logic             req_byp
);

  localparam logic [DIV_W-1:0] HALF_MAX = {DIV_W{1'b1}};
  localparam logic [DIV_W-1:0] HALF_MIN = {{(DIV_W-1){1'b0}}, 1'b1};

  // half-period length in master cycles
  function automatic logic [DIV_W-1:0] half_len(input logic [DIV_W-1:0] d,
                                                input logic ddr,
                                                input logic off);
    if (off)             return HALF_MAX;
    else if (d == '0)    return HALF_MIN;
    else                 return d;
  endfunction

  function automatic logic wants_bypass(input logic [DIV_W-1:0] d,
                                        input logic ddr,
                                        input logic off);
    return (d == '0) && !ddr && !off;
  endfunction

  always_comb begin
    req_half = half_len(div_val, ddr_req, off_req);
    req_byp  = wants_bypass(div_val, ddr_req, off_req);
  end

endmodule

// File: rtl/ckd_divcore.sv
module ckd_divcore #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] req_half,
  input  logic             req_byp,
  input  logic             req_ddr,
  input  logic             stall,
  output logic             div_q,
  output logic             act_byp,
  output logic             act_ddr,
  output logic             load_evt,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             byp_nxt
);

  localparam logic [DIV_W-1:0] HALF_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] act_half;
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == (act_half - HALF_ONE));

  // settings are adopted every cycle while bypassing, else at a falling transition
  always_comb begin
    load_evt = act_byp | (at_end & div_q);
    rise_evt = ~act_byp & at_end & ~div_q & ~stall;
    fall_evt = ~act_byp & at_end & div_q;
    byp_nxt  = load_evt ? req_byp : act_byp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= 1'b0;
      act_byp  <= 1'b1;
      act_ddr  <= 1'b0;
      act_half <= HALF_ONE;
      cnt      <= '0;
    end else if (load_evt) begin
      act_half <= req_half;
      act_byp  <= req_byp;
      act_ddr  <= req_ddr;
      cnt      <= '0;
      div_q    <= 1'b0;
    end else if (rise_evt) begin
      cnt      <= '0;
      div_q    <= 1'b1;
    end else if (!at_end) begin
      cnt      <= cnt + HALF_ONE;
    end
  end

endmodule

// File: rtl/ckd_byp_gate.sv
module ckd_byp_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic byp_nxt,
  input  logic stall,
  output logic gate_req,
  output logic gate_q
);

  // decision taken on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_req <= 1'b0;
    else        gate_req <= byp_nxt & ~stall;
  end

  // applied while the master clock is low, so the gated clock never chops
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_req;
  end

endmodule

// File: rtl/ckd_bus_cfg.sv
module ckd_bus_cfg
  import ckd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_width_req,
  input  logic       hs_req,
  input  logic       hwfc_req,
  output logic [1:0] bus_width,
  output logic       hs_bus,
  output logic       hwfc_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_width <= BW_ONE;
      hs_bus    <= 1'b0;
      hwfc_en   <= 1'b0;
    end else begin
      bus_width <= norm_width(bus_width_req);
      hs_bus    <= hs_req;
      hwfc_en   <= hwfc_req;
    end
  end

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_mst,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             clk_off_req,
  input  logic             ddr_req,
  input  logic [1:0]       bus_width_req,
  input  logic             hs_req,
  input  logic             hwfc_req,
  input  logic             fifo_stall,
  output logic             card_clk,
  output logic             clk_en,
  output logic [1:0]       bus_width,
  output logic             ddr_act,
  output logic             hs_bus,
  output logic             hwfc_en
);

  logic [DIV_W-1:0] req_half;
  logic             req_byp;
  logic             div_q;
  logic             act_byp;
  logic             load_evt;
  logic             rise_evt;
  logic             fall_evt;
  logic             byp_nxt;
  logic             gate_req;
  logic             gate_q;
  logic             stall_evt;

  assign stall_evt = hwfc_en & fifo_stall;

  ckd_cfg_sel #(.DIV_W(DIV_W)) u_sel (
    .div_val  (div_val),
    .ddr_req  (ddr_req),
    .off_req  (clk_off_req),
    .req_half (req_half),
    .req_byp  (req_byp)
  );

  ckd_divcore #(.DIV_W(DIV_W)) u_core (
    .clk      (clk_mst),
    .rst_n    (rst_n),
    .req_half (req_half),
    .req_byp  (req_byp),
    .req_ddr  (ddr_req),
    .stall    (stall_evt),
    .div_q    (div_q),
    .act_byp  (act_byp),
    .act_ddr  (ddr_act),
    .load_evt (load_evt),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .byp_nxt  (byp_nxt)
  );

  ckd_byp_gate u_gate (
    .clk      (clk_mst),
    .rst_n    (rst_n),
    .byp_nxt  (byp_nxt),
    .stall    (stall_evt),
    .gate_req (gate_req),
    .gate_q   (gate_q)
  );

  ckd_bus_cfg u_bus (
    .clk           (clk_mst),
    .rst_n         (rst_n),
    .bus_width_req (bus_width_req),
    .hs_req        (hs_req),
    .hwfc_req      (hwfc_req),
    .bus_width     (bus_width),
    .hs_bus        (hs_bus),
    .hwfc_en       (hwfc_en)
  );

  // launch strobe: rising edge, plus falling edge in DDR, every cycle when bypassing
  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) clk_en <= 1'b0;
    else        clk_en <= rise_evt | (fall_evt & ddr_act) | gate_req;
  end

  assign card_clk = (clk_mst & gate_q) | div_q;

endmodule

// File: rtl/ckd_chk.sv
module ckd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       div_q,
  input logic       gate_q,
  input logic       act_byp,
  input logic       load_evt,
  input logic       ce,
  input logic       ddr_act,
  input logic       stall,
  input logic [1:0] bw_req,
  input logic [1:0] bw_out
);

  // R6
  mux_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_q && gate_q));

  // R5
  load_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !act_byp) |-> div_q);

  // R7
  stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !div_q && !act_byp) |=> !div_q);

  // R8
  ce_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_q) |-> ce);

  // R8
  ce_ddr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_q) && $past(ddr_act)) |-> ce);

  // R3
  ddr_no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_act |-> !act_byp);

  // R9
  bw_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bw_req) == 2'b11) |-> (bw_out == 2'b00));

endmodule

bind card_clk_div ckd_chk u_ckd_chk (
  .clk      (clk_mst),
  .rst_n    (rst_n),
  .div_q    (div_q),
  .gate_q   (gate_q),
  .act_byp  (act_byp),
  .load_evt (load_evt),
  .ce       (clk_en),
  .ddr_act  (ddr_act),
  .stall    (stall_evt),
  .bw_req   (bus_width_req),
  .bw_out   (bus_width)
);

// File: tb/card_clk_div_bench.sv
`timescale 1ns/1ps
module card_clk_div_bench;
  localparam int DW = 8;
  localparam int NV = 8;
  // entry: {divider, ddr, off, expected half length}
  localparam logic [17:0] VEC [NV] = '{
    {8'd1,   1'b0, 1'b0, 8'd1},
    {8'd3,   1'b0, 1'b0, 8'd3},
    {8'd5,   1'b1, 1'b0, 8'd5},
    {8'd0,   1'b1, 1'b0, 8'd1},
    {8'd0,   1'b0, 1'b1, 8'd255},
    {8'd7,   1'b0, 1'b1, 8'd255},
    {8'd2,   1'b0, 1'b0, 8'd2},
    {8'd255, 1'b0, 1'b0, 8'd255}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [DW-1:0] div_val = 8'd1;
  logic          clk_off_req = 1'b0, ddr_req = 1'b0, hs_req = 1'b0;
  logic          hwfc_req = 1'b0, fifo_stall = 1'b0;
  logic [1:0]    bus_width_req = 2'b00;
  logic          card_clk, clk_en, ddr_act, hs_bus, hwfc_en;
  logic [1:0]    bus_width;

  card_clk_div #(.DIV_W(DW)) u_card_clk_div (
    .clk_mst(clk), .rst_n(rst_n), .div_val(div_val), .clk_off_req(clk_off_req),
    .ddr_req(ddr_req), .bus_width_req(bus_width_req), .hs_req(hs_req),
    .hwfc_req(hwfc_req), .fifo_stall(fifo_stall), .card_clk(card_clk),
    .clk_en(clk_en), .bus_width(bus_width), .ddr_act(ddr_act),
    .hs_bus(hs_bus), .hwfc_en(hwfc_en)
  );

  int checks = 0, errors = 0, cyc = 0, glitches = 0;
  bit armed = 1'b0;
  realtime last_t = 0.0;

  always @(posedge clk) cyc++;

  // R6 pulse-width monitor
  always @(card_clk) begin
    if (armed && ($realtime - last_t < 3.5)) glitches++;
    last_t = $realtime;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic smp();
    @(posedge clk); #6;
  endtask

  task automatic measure(output int hi, output int lo, output int ce);
    int guard = 0;
    hi = 0; lo = 0; ce = 0;
    smp();
    while (card_clk !== 1'b0 && guard < 3000) begin smp(); guard++; end
    while (card_clk !== 1'b1 && guard < 3000) begin smp(); guard++; end
    while (card_clk === 1'b1 && guard < 3000) begin
      hi++; if (clk_en) ce++; smp(); guard++;
    end
    while (card_clk === 1'b0 && guard < 3000) begin
      lo++; if (clk_en) ce++; smp(); guard++;
    end
  endtask

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, ce, bad;
    // R11 reset state
    repeat (3) smp();
    chk(card_clk == 1'b0 && clk_en == 1'b0, "R11 clock/strobe in reset", {card_clk, clk_en}, 0);
    chk(ddr_act == 1'b0 && bus_width == 2'b00 && hs_bus == 1'b0 && hwfc_en == 1'b0,
        "R11 config in reset", {ddr_act, bus_width, hs_bus, hwfc_en}, 0);
    rst_n = 1'b1;
    smp();
    armed = 1'b1;

    // R1 R3 R4 R8 R10 table
    for (int i = 0; i < NV; i++) begin
      div_val = VEC[i][17:10]; ddr_req = VEC[i][9]; clk_off_req = VEC[i][8];
      measure(hi, lo, ce);
      measure(hi, lo, ce);
      chk(hi == int'(VEC[i][7:0]), "R1/R3/R4 high half", hi, int'(VEC[i][7:0]));
      chk(lo == int'(VEC[i][7:0]), "R1/R3/R4 low half", lo, int'(VEC[i][7:0]));
      chk(ce == (VEC[i][9] ? 2 : 1), "R8 strobes per period", ce, VEC[i][9] ? 2 : 1);
      chk(ddr_act == VEC[i][9], "R10 ddr_act", ddr_act, VEC[i][9]);
    end
    ddr_req = 1'b0; clk_off_req = 1'b0;

    // R5 change while high
    div_val = 8'd3;
    measure(hi, lo, ce);
    measure(hi, lo, ce);
    div_val = 8'd6;   // at the first high sample
    hi = 0; lo = 0;
    while (card_clk === 1'b1 && hi < 600) begin hi++; smp(); end
    while (card_clk === 1'b0 && lo < 600) begin lo++; smp(); end
    chk(hi == 3, "R5 current high keeps old divider", hi, 3);
    chk(lo == 6, "R5 next low uses new divider", lo, 6);
    hi = 0;
    while (card_clk === 1'b1 && hi < 600) begin hi++; smp(); end
    chk(hi == 6, "R5 next high uses new divider", hi, 6);

    // R7 flow-control stall in divided mode
    div_val = 8'd4;
    measure(hi, lo, ce);
    hwfc_req = 1'b1; fifo_stall = 1'b1;
    repeat (12) smp();
    bad = 0;
    repeat (20) begin smp(); if (card_clk || clk_en) bad++; end
    chk(bad == 0, "R7 parked low while stalled", bad, 0);
    fifo_stall = 1'b0;
    measure(hi, lo, ce);
    measure(hi, lo, ce);
    chk(hi == 4 && lo == 4, "R7 resumes after stall", hi * 100 + lo, 404);
    hwfc_req = 1'b0; fifo_stall = 1'b1;
    measure(hi, lo, ce);
    measure(hi, lo, ce);
    chk(hi == 4 && lo == 4, "R7 stall ignored without flow control", hi * 100 + lo, 404);
    fifo_stall = 1'b0;

    // R2 bypass
    div_val = 8'd0;
    repeat (12) smp();
    bad = 0;
    repeat (8) begin
      @(posedge clk); #2;
      if (card_clk !== 1'b1) bad++;
      #4;
      if (card_clk !== 1'b0 || clk_en !== 1'b1) bad++;
    end
    chk(bad == 0, "R2 bypass follows master clock", bad, 0);

    // R7 stall in bypass
    hwfc_req = 1'b1; fifo_stall = 1'b1;
    repeat (3) smp();
    bad = 0;
    repeat (8) begin
      @(posedge clk); #2;
      if (card_clk !== 1'b0) bad++;
      #4;
      if (clk_en !== 1'b0) bad++;
    end
    chk(bad == 0, "R7 bypass parked low while stalled", bad, 0);
    fifo_stall = 1'b0; hwfc_req = 1'b0;

    // R6 bypass to divided and back to divided
    div_val = 8'd2;
    measure(hi, lo, ce);
    measure(hi, lo, ce);
    chk(hi == 2 && lo == 2, "R6 divided after bypass", hi * 100 + lo, 202);

    // R9 R10 bus options
    for (int c = 0; c < 4; c++) begin
      bus_width_req = 2'(c); hs_req = c[0]; hwfc_req = c[1];
      smp();
      chk(bus_width == ((c == 3) ? 2'b00 : 2'(c)), "R9 bus width code", bus_width,
          (c == 3) ? 0 : c);
      chk(hs_bus == c[0] && hwfc_en == c[1], "R10 hs/flow-control flags",
          {hs_bus, hwfc_en}, {c[0], c[1]});
    end
    hwfc_req = 1'b0;

    repeat (4) smp();
    chk(glitches == 0, "R6 no short pulse", glitches, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule